// File: doc/BRIEF.md
# Backup Timekeeping Counter

This block keeps time for a chip while the rest of it sleeps. A free-running counter is advanced by pulses from one of three slow clock sources. A power-of-two prescaler sits between the selected source and the counter. The counter wraps at all ones. Optionally, it also wraps when it matches a single compare register. Two sticky event flags, one for overflow and one for compare, are cleared by a write-one mask.

Software first writes an 11-bit control word. That write always leaves the counter and the prescaler cleared and holds them in reset. A separate hold write then releases the counter. The compare can run at reduced precision by ignoring a chosen number of low counter bits. When the ultra-low source is selected, a prescaler exponent of zero doubles its tick rate rather than dividing it.

The source inputs are single-cycle pulse strobes in the `clk` domain. The oscillators and any bus decoding are outside the block.

Top module: `bkrtc_top`

## Requirements
- R1: After reset, `count_o` is 0 and `flags_o` is 0. The counter is held, and the source select is NONE.
- R2: A `ctrl_wr` pulse loads `ctrl_word` into the configuration. In the same cycle it clears the counter and the prescaler and sets the hold. The control word has these fields: run mode in [1:0] (00 means stopped; any other value means running), prescaler exponent in [4:2], compare-as-top in [5], low-bit compare mask count in [8:6], and source select in [10:9] (00 NONE, 01 RC source, 10 crystal source, 11 ultra-low source).
- R3: While the hold is set, the counter reads 0 and the prescaler stays cleared. A `hold_wr` pulse loads `hold_val` into the hold; `ctrl_wr` takes priority over it.
- R4: For the RC and crystal sources, the counter advances once per 2^E pulses of the selected source, where E is the exponent. The first advance after release comes a full 2^E pulses later.
- R5: For the ultra-low source, exponent 0 advances the counter on every pulse. Any other exponent advances it on every second pulse.
- R6: With source select NONE, or with run mode 00, the counter does not advance.
- R7: The compare ignores the M least-significant bits, where M is the mask field and a value of 7 acts as 6. `flags_o[1]` sets on an advance where the counter, masked this way, equals the compare register. A `cmp_wr` pulse loads the compare register from `cmp_word`.
- R8: With compare-as-top set, an advance on a masked match loads the counter with 0 instead of incrementing it.
- R9: `flags_o[0]` sets on an advance that takes the counter from all ones to 0 by incrementing.
- R10: Bits of `flag_clr` written as 1 clear the matching flags, with bit 0 for overflow and bit 1 for compare. Clear bits 31:2 have no effect. When a clear and a new event hit the same flag in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the source pulses are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| ctrl_wr | input | 1 | Load the control word and force the counter into hold |
| ctrl_word | input | 11 | Configuration fields (see R2) |
| hold_wr | input | 1 | Load the hold bit |
| hold_val | input | 1 | New hold value; 0 releases the counter |
| cmp_wr | input | 1 | Load the compare register |
| cmp_word | input | 32 | New compare value |
| flag_clr | input | 32 | Write-one-to-clear mask for the flags |
| src_rc | input | 1 | RC source tick pulse |
| src_xo | input | 1 | Crystal source tick pulse |
| src_ulf | input | 1 | Ultra-low source tick pulse |
| count_o | output | 32 | Counter value |
| flags_o | output | 2 | Sticky flags: bit 0 overflow, bit 1 compare |

## Verification
The overflow flag is the hardest state to reach. A full-width counter needs 2^32 advances before it wraps, and nothing at the ports can preload it. The bench therefore builds the block with a 12-bit counter and drives the RC source with a pulse on every cycle at divide-by-one, so the wrap from all ones happens after 4096 advances. To reach a clear that coincides with a new event, the bench holds the clear mask at all ones and uses compare-as-top with a small compare value, which makes the compare match repeat every few cycles.

// File: rtl/bkrtc_pkg.sv
package bkrtc_pkg;

  localparam int CTRL_W  = 11;
  localparam int PEXP_W  = 3;
  localparam int LPM_W   = 3;
  localparam int DIV_W   = (1 << PEXP_W) - 1;
  localparam int NFLAG   = 2;
  localparam int CLR_W   = 32;
  localparam int FLG_OVF = 0;
  localparam int FLG_CMP = 1;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RC   = 2'd1,
    SRC_XO   = 2'd2,
    SRC_ULF  = 2'd3
  } src_sel_e;

  typedef struct packed {
    src_sel_e              src;
    logic [LPM_W-1:0]      lpm;
    logic                  top;
    logic [PEXP_W-1:0]     pexp;
    logic [1:0]            mode;
  } cfg_t;

endpackage

// File: rtl/bkrtc_presc.sv
module bkrtc_presc
  import bkrtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               run,
  input  src_sel_e           src,
  input  logic [PEXP_W-1:0]  pexp,
  input  logic               src_rc,
  input  logic               src_xo,
  input  logic               src_ulf,
  output logic               tick
);

  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  div_d;
  logic [DIV_W-1:0]  term;
  logic [PEXP_W-1:0] eff_exp;
  logic              pulse;

  // pick the source pulse; a stopped mode or NONE yields no pulses
  always_comb begin
    unique case (src)
      SRC_RC:  pulse = src_rc;
      SRC_XO:  pulse = src_xo;
      SRC_ULF: pulse = src_ulf;
      default: pulse = 1'b0;
    endcase
    pulse = pulse & run;
  end

  // ultra-low source: exponent 0 keeps every pulse, others keep one in two
  assign eff_exp = (src == SRC_ULF) ? {{(PEXP_W-1){1'b0}}, (pexp != '0)} : pexp;

  // terminal count = 2^eff_exp - 1, built bit by bit
  for (genvar i = 0; i < DIV_W; i++) begin : g_term
    assign term[i] = (int'(eff_exp) > i);
  end

  assign tick = pulse && (div_q == term);

  always_comb begin
    div_d = div_q;
    if (restart)    div_d = '0;
    else if (pulse) div_d = tick ? '0 : div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

endmodule

// File: rtl/bkrtc_cmp.sv
module bkrtc_cmp
  import bkrtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LP_MAX = 6
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] ref_val,
  input  logic [LPM_W-1:0] lpm,
  output logic             match
);

  logic [LPM_W-1:0] lp_eff;
  logic [CNT_W-1:0] care;

  // mask counts above the limit saturate
  assign lp_eff = (int'(lpm) > LP_MAX) ? LPM_W'(LP_MAX) : lpm;

  for (genvar i = 0; i < CNT_W; i++) begin : g_care
    assign care[i] = (i >= int'(lp_eff));
  end

  assign match = ~|((count ^ ref_val) & care);

endmodule

// File: rtl/bkrtc_flags.sv
module bkrtc_flags
#(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags
);

  logic [NF-1:0] flg_d;

  // a new event outranks a clear in the same cycle
  assign flg_d = (flags & ~clr) | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flg_d;
  end

endmodule

// File: rtl/bkrtc_top.sv
module bkrtc_top
  import bkrtc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LP_MAX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              hold_wr,
  input  logic              hold_val,
  input  logic              cmp_wr,
  input  logic [CNT_W-1:0]  cmp_word,
  input  logic [CLR_W-1:0]  flag_clr,
  input  logic              src_rc,
  input  logic              src_xo,
  input  logic              src_ulf,
  output logic [CNT_W-1:0]  count_o,
  output logic [NFLAG-1:0]  flags_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  cfg_t             cfg_q, cfg_d;
  logic             hold_q, hold_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             restart;
  logic             tick;
  logic             adv;
  logic             cmp_match;
  logic             reload;
  logic [NFLAG-1:0] flg_set;
  src_sel_e         src_cur;
  logic             unused_clr_hi;

  assign src_cur       = cfg_q.src;
  assign restart       = ctrl_wr | hold_q;
  assign unused_clr_hi = ^flag_clr[CLR_W-1:NFLAG];

  bkrtc_presc u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (|cfg_q.mode),
    .src     (src_cur),
    .pexp    (cfg_q.pexp),
    .src_rc  (src_rc),
    .src_xo  (src_xo),
    .src_ulf (src_ulf),
    .tick    (tick)
  );

  bkrtc_cmp #(.CNT_W(CNT_W), .LP_MAX(LP_MAX)) u_cmp (
    .count   (cnt_q),
    .ref_val (cmp_q),
    .lpm     (cfg_q.lpm),
    .match   (cmp_match)
  );

  assign adv    = tick & ~restart;
  assign reload = cfg_q.top & cmp_match;

  always_comb begin
    flg_set          = '0;
    flg_set[FLG_OVF] = adv & ~reload & (&cnt_q);
    flg_set[FLG_CMP] = adv & cmp_match;
  end

  bkrtc_flags #(.NF(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flg_set),
    .clr   (flag_clr[NFLAG-1:0]),
    .flags (flags_o)
  );

  // next-state
  always_comb begin
    cfg_d  = ctrl_wr ? cfg_t'(ctrl_word) : cfg_q;
    cmp_d  = cmp_wr ? cmp_word : cmp_q;
    hold_d = hold_q;
    if (ctrl_wr)      hold_d = 1'b1;
    else if (hold_wr) hold_d = hold_val;
    cnt_d = cnt_q;
    if (restart)  cnt_d = '0;
    else if (adv) cnt_d = reload ? '0 : cnt_q + CNT_ONE;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cmp_q  <= '0;
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      cmp_q  <= cmp_d;
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/bkrtc_chk.sv
module bkrtc_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic             hold_q,
  input logic             adv,
  input logic             reload,
  input logic             cmp_match,
  input logic [1:0]       src_cur,
  input logic [1:0]       flag_clr_lo,
  input logic [CNT_W-1:0] count_o,
  input logic [1:0]       flags_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> count_o == '0);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reload) |=> count_o == $past(count_o) + ONE);

  p_no_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_cur == 2'b00 && !ctrl_wr) |=> (count_o == '0 || $stable(count_o)));

  p_cmp_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cmp_match) |=> flags_o[1]);

  p_top_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && reload) |=> count_o == '0);

  p_ovf_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reload && (&count_o)) |=> flags_o[0]);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[0] && !flag_clr_lo[0]) |=> flags_o[0]);

endmodule

bind bkrtc_top bkrtc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_wr     (ctrl_wr),
  .hold_q      (hold_q),
  .adv         (adv),
  .reload      (reload),
  .cmp_match   (cmp_match),
  .src_cur     (src_cur),
  .flag_clr_lo (flag_clr[1:0]),
  .count_o     (count_o),
  .flags_o     (flags_o)
);

// File: tb/bkrtc_top_tb.sv
module bkrtc_top_tb;

  localparam int CW   = 12;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctrl_wr = 1'b0;
  logic [10:0]   ctrl_word = '0;
  logic          hold_wr = 1'b0;
  logic          hold_val = 1'b0;
  logic          cmp_wr = 1'b0;
  logic [CW-1:0] cmp_word = '0;
  logic [31:0]   flag_clr = '0;
  logic          src_rc = 1'b0;
  logic          src_xo = 1'b0;
  logic          src_ulf = 1'b0;
  logic [CW-1:0] count_o;
  logic [1:0]    flags_o;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit live = 0;
  int per_rc = 1, per_xo = 3, per_ulf = 5, cyc = 0;

  // behavioural model state
  int m_cnt, m_div, m_hold, m_cfg, m_cmp, m_flags;

  bkrtc_top #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word),
    .hold_wr(hold_wr), .hold_val(hold_val), .cmp_wr(cmp_wr), .cmp_word(cmp_word),
    .flag_clr(flag_clr), .src_rc(src_rc), .src_xo(src_xo), .src_ulf(src_ulf),
    .count_o(count_o), .flags_o(flags_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp_v, $time);
    end
  endtask

  // source pulse trains
  always @(negedge clk) begin
    cyc++;
    src_rc  <= (cyc % per_rc) == 0;
    src_xo  <= (cyc % per_xo) == 0;
    src_ulf <= (cyc % per_ulf) == 0;
  end

  // reference model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_div = 0; m_hold = 1; m_cfg = 0; m_cmp = 0; m_flags = 0;
    end else begin
      int src, pexp, lpm, top, per, lp, n_cnt, n_div, setv;
      bit run, pulse, tk, rs, adv, mt;
      src  = (m_cfg >> 9) & 3;
      lpm  = (m_cfg >> 6) & 7;
      top  = (m_cfg >> 5) & 1;
      pexp = (m_cfg >> 2) & 7;
      run  = (m_cfg & 3) != 0;
      case (src)
        1: pulse = src_rc;
        2: pulse = src_xo;
        3: pulse = src_ulf;
        default: pulse = 0;
      endcase
      pulse = pulse && run;
      if (src == 3) per = (pexp == 0) ? 1 : 2;
      else          per = 1 << pexp;
      tk  = pulse && (m_div == per - 1);
      rs  = (m_hold != 0) || ctrl_wr;
      adv = tk && !rs;
      lp  = (lpm > 6) ? 6 : lpm;
      mt  = (m_cnt >> lp) == (m_cmp >> lp);
      setv = 0;
      n_cnt = m_cnt;
      if (rs) n_cnt = 0;
      else if (adv) begin
        if (top != 0 && mt) n_cnt = 0;
        else begin
          n_cnt = (m_cnt + 1) & MAXV;
          if (m_cnt == MAXV) setv |= 1;
        end
        if (mt) setv |= 2;
      end
      if (rs) n_div = 0;
      else if (pulse) n_div = tk ? 0 : m_div + 1;
      else n_div = m_div;
      m_flags = ((m_flags & ~int'(flag_clr[1:0])) & 3) | setv;
      if (ctrl_wr) m_hold = 1;
      else if (hold_wr) m_hold = hold_val;
      if (ctrl_wr) m_cfg = ctrl_word;
      if (cmp_wr) m_cmp = cmp_word;
      m_cnt = n_cnt;
      m_div = n_div;
    end
  end

  // compare against the model every cycle
  always @(negedge clk) begin
    if (live) begin
      chk(cur_req, int'(count_o), m_cnt, "count vs model");
      chk(cur_req, int'(flags_o), m_flags, "flags vs model");
    end
  end

  function automatic logic [10:0] mk(int mode, int pexp, int top, int lpm, int src);
    return {2'(src), 3'(lpm), 1'(top), 3'(pexp), 2'(mode)};
  endfunction

  task automatic wr_ctrl(input logic [10:0] w);
    ctrl_word = w; ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic release_hold();
    hold_wr = 1'b1; hold_val = 1'b0;
    @(negedge clk);
    hold_wr = 1'b0;
  endtask

  task automatic wr_cmp(input int v);
    cmp_word = CW'(v); cmp_wr = 1'b1;
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic clr_all();
    flag_clr = 32'hFFFF_FFFF;
    @(negedge clk);
    flag_clr = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [1:0] keep;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1;
    // R1: reset state
    cur_req = "R1";
    chk("R1", int'(count_o), 0, "count after reset");
    chk("R1", int'(flags_o), 0, "flags after reset");
    idle(10);
    chk("R1", int'(count_o), 0, "counter idle while held with NONE source");

    // R3: held until released; R4: first tick one full period later
    cur_req = "R3";
    wr_ctrl(mk(1, 2, 0, 0, 1));
    idle(20);
    chk("R3", int'(count_o), 0, "held after config write");
    cur_req = "R4";
    release_hold();
    idle(40);
    chk("R4", int'(count_o), 10, "RC source divide-by-4 after 40 pulses");
    // R2: config write clears a running counter and holds it
    cur_req = "R2";
    wr_ctrl(mk(1, 0, 0, 0, 1));
    chk("R2", int'(count_o), 0, "count cleared by config write");
    idle(10);
    chk("R3", int'(count_o), 0, "still held after config write");

    // R6: NONE source and stopped mode
    cur_req = "R6";
    wr_ctrl(mk(1, 0, 0, 0, 0));
    release_hold();
    idle(30);
    chk("R6", int'(count_o), 0, "NONE source does not advance");
    wr_ctrl(mk(0, 0, 0, 0, 1));
    release_hold();
    idle(30);
    chk("R6", int'(count_o), 0, "stopped mode does not advance");

    // R5: ultra-low source
    cur_req = "R5";
    per_ulf = 1;
    wr_ctrl(mk(1, 0, 0, 0, 3));
    release_hold();
    idle(30);
    chk("R5", int'(count_o), 30, "ultra-low exponent 0 every pulse");
    wr_ctrl(mk(1, 5, 0, 0, 3));
    release_hold();
    idle(30);
    chk("R5", int'(count_o), 15, "ultra-low exponent 5 every second pulse");
    per_ulf = 5;
    wr_ctrl(mk(1, 3, 0, 0, 3));
    release_hold();
    idle(100);

    // R4: crystal source with sparse pulses, checked by the model
    cur_req = "R4";
    wr_ctrl(mk(1, 1, 0, 0, 2));
    release_hold();
    idle(200);

    // R7 / R8: compare-as-top, exact and masked
    cur_req = "R8";
    wr_cmp(20);
    wr_ctrl(mk(1, 0, 1, 0, 1));
    clr_all();
    release_hold();
    idle(20);
    chk("R8", int'(count_o), 20, "count reaches compare value");
    idle(1);
    chk("R8", int'(count_o), 0, "wrap on compare match");
    chk("R7", int'(flags_o[1]), 1, "compare flag on match");
    flag_clr = 32'h2;
    @(negedge clk);
    flag_clr = '0;
    chk("R10", int'(flags_o[1]), 0, "compare flag cleared by mask");
    cur_req = "R7";
    wr_cmp(22);
    wr_ctrl(mk(1, 0, 1, 2, 1));
    release_hold();
    idle(21);
    chk("R7", int'(count_o), 0, "two low bits ignored: wrap at 20");
    wr_cmp(100);
    wr_ctrl(mk(1, 0, 1, 7, 1));
    release_hold();
    idle(64);
    chk("R7", int'(count_o), 64, "mask 7 acts as 6: reaches 64");
    idle(1);
    chk("R7", int'(count_o), 0, "mask 7 acts as 6: wrap after 64");

    // R9: overflow on the narrowed counter
    cur_req = "R9";
    wr_cmp(0);
    wr_ctrl(mk(1, 0, 0, 0, 1));
    clr_all();
    release_hold();
    idle(MAXV);
    chk("R9", int'(count_o), MAXV, "count at all ones");
    chk("R9", int'(flags_o[0]), 0, "no overflow before wrap");
    idle(1);
    chk("R9", int'(count_o), 0, "count wrapped");
    chk("R9", int'(flags_o[0]), 1, "overflow flag on wrap");

    // R10: high clear bits ignored; set outranks clear
    cur_req = "R10";
    keep = flags_o;
    flag_clr = 32'hFFFF_FFFC;
    @(negedge clk);
    flag_clr = '0;
    chk("R10", int'(flags_o[0]), int'(keep[0]), "clear bits 31:2 ignored");
    wr_cmp(5);
    wr_ctrl(mk(1, 0, 1, 0, 1));
    flag_clr = 32'h3;
    release_hold();
    idle(5);
    chk("R10", int'(flags_o), 0, "flags cleared under continuous mask");
    idle(1);
    chk("R10", int'(flags_o[1]), 1, "event wins over coincident clear");
    idle(1);
    chk("R10", int'(flags_o[1]), 0, "clear takes effect once events stop");
    idle(30);
    flag_clr = '0;
    idle(20);

    live = 0;
    finish_run();
  end

endmodule